// File: doc/BRIEF.md
# Multi-Cycle CPU Bus Fetch Sequencer

This block is the control sequencer of a small 8-bit processor that shares one system bus with a simple synchronous memory. The bus is made of a 16-bit address, an 8-bit data path and one memory-request strobe. The sequencer splits every instruction into separate bus cycles: fetch, memory response, decode and execute. During those cycles it drives the address and the request strobe, and it captures the bytes that memory places on the data path.

The bus lines are held in registers. Each agent on the bus, first the sequencer and then the memory, can ask for an update during a cycle. The update takes effect at the end of that cycle, and only the first agent to ask in a cycle is served. A later request in the same cycle is discarded whole.

Two instructions are supported. The no-operation takes four cycles and leaves the bus untouched in its execute cycle. The load-immediate carries one operand byte: the sequencer fetches that byte straight after the decode cycle, then copies it into accumulator A and moves the program counter past it. Every other opcode value is run as a no-operation.

Top module: `cpu_bus_seq`

## Requirements
- R1: While reset is active, and straight after it, the bus address is 0x0000, the bus data is 0x00, the request strobe is low and accumulator A is 0x00. The first fetch after reset uses address 0x0000.
- R2: A bus update asked for during a cycle shows on the outputs only after that cycle's clock edge. When the sequencer and the memory both ask in the same cycle, the sequencer wins and the memory's data byte is discarded. This happens in every decode cycle and every operand-load cycle, because memory still sees the strobe high there.
- R3: In a fetch cycle the address becomes the program counter and the strobe goes high. The data value is left unchanged.
- R4: In the cycle after a fetch, the data value becomes the memory byte at the fetched address. Address and strobe are unchanged.
- R5: In the decode cycle the strobe goes low. Address and data are unchanged.
- R6: The no-operation code 0x00 takes exactly four cycles. Its execute cycle changes no bus line and does not change A. The next fetch uses the previous address plus one.
- R7: The load-immediate code 0x3E is followed by a fetch at its own address plus one, with the strobe high, in the cycle right after its decode cycle.
- R8: After the operand's memory-response cycle there is one load cycle. In that cycle the strobe goes low and A takes the operand byte. The next opcode fetch is at the operand address plus one.
- R9: Any opcode other than 0x3E goes through the same four-cycle sequence as the no-operation, leaves A unchanged, and advances the address by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every bus update resolves on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_wr_en | input | 1 | Memory asks to place a byte on the data path in this cycle |
| mem_wr_data | input | 8 | Byte the memory offers |
| bus_addr | output | 16 | Registered bus address |
| bus_data | output | 8 | Registered bus data value |
| bus_req | output | 1 | Registered memory-request strobe |
| acc_a | output | 8 | Accumulator A |

## Verification
The case that is hardest to reach from the ports is the one where both agents ask in the same cycle and the memory's request is dropped. A memory that answers on the strobe alone does exactly this in every decode and operand-load cycle, because the strobe is still high from the response cycle. The bench therefore models memory as a responder that asks for a write whenever the strobe is high. It checks that the data value does not change in those cycles, even though a write was requested. The program is swept over several operand values, with an unknown opcode placed between the loads. One run is reset in the middle of an instruction.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

   // Bus field indices used in write masks
   localparam int FLD_ADDR = 0;
   localparam int FLD_DATA = 1;
   localparam int FLD_REQ  = 2;
   localparam int NUM_FLD  = 3;

   // Writer slots on the shared bus, lowest index has precedence
   localparam int WR_CPU  = 0;
   localparam int WR_MEM  = 1;
   localparam int NUM_WR  = 2;

   typedef enum logic [2:0] {
      ST_FETCH   = 3'd0,
      ST_RESP    = 3'd1,
      ST_DECODE  = 3'd2,
      ST_EXEC    = 3'd3,
      ST_OPFETCH = 3'd4,
      ST_OPRESP  = 3'd5,
      ST_LOAD    = 3'd6
   } seq_state_e;

endpackage

// File: rtl/bus_wr_arbiter.sv
module bus_wr_arbiter
   import cbs_pkg::*;
#(
   parameter int N  = 2,
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic [N-1:0]              wr_en,
   input  logic [N-1:0][NUM_FLD-1:0] wr_mask,
   input  logic [N-1:0][AW-1:0]      wr_addr,
   input  logic [N-1:0][DW-1:0]      wr_data,
   input  logic [N-1:0]              wr_req,
   output logic                      win_en,
   output logic [NUM_FLD-1:0]        win_mask,
   output logic [AW-1:0]             win_addr,
   output logic [DW-1:0]             win_data,
   output logic                      win_req
);

   generate
      if (N < 1) begin : g_bad_n
         $error("bus_wr_arbiter: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] taken;
   logic [N-1:0] grant;

   // Priority chain: the first enabled writer claims the whole cycle
   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         if (i == 0) begin : g_head
            assign grant[i] = wr_en[i];
            assign taken[i] = wr_en[i];
         end else begin : g_link
            assign grant[i] = wr_en[i] & ~taken[i-1];
            assign taken[i] = wr_en[i] | taken[i-1];
         end
      end
   endgenerate

   always_comb begin
      win_mask = '0;
      win_addr = '0;
      win_data = '0;
      win_req  = 1'b0;
      for (int k = 0; k < N; k++) begin
         if (grant[k]) begin
            win_mask = win_mask | wr_mask[k];
            win_addr = win_addr | wr_addr[k];
            win_data = win_data | wr_data[k];
            win_req  = win_req  | wr_req[k];
         end
      end
   end

   assign win_en = taken[N-1];

endmodule

// File: rtl/bus_state_reg.sv
module bus_state_reg
   import cbs_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_en,
   input  logic [NUM_FLD-1:0] upd_mask,
   input  logic [AW-1:0]      upd_addr,
   input  logic [DW-1:0]      upd_data,
   input  logic               upd_req,
   output logic [AW-1:0]      bus_addr,
   output logic [DW-1:0]      bus_data,
   output logic               bus_req
);

   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          req_q;

   // Deferred update: whatever won this cycle lands at the edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         req_q  <= 1'b0;
      end else if (upd_en) begin
         if (upd_mask[FLD_ADDR]) addr_q <= upd_addr;
         if (upd_mask[FLD_DATA]) data_q <= upd_data;
         if (upd_mask[FLD_REQ])  req_q  <= upd_req;
      end
   end

   assign bus_addr = addr_q;
   assign bus_data = data_q;
   assign bus_req  = req_q;

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import cbs_pkg::*;
#(
   parameter int          AW       = 16,
   parameter int          DW       = 8,
   parameter logic [7:0]  LDI_CODE = 8'h3E
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DW-1:0]      bus_data_i,
   output logic               wr_en,
   output logic [NUM_FLD-1:0] wr_mask,
   output logic [AW-1:0]      wr_addr,
   output logic [DW-1:0]      wr_data,
   output logic               wr_req,
   output logic [DW-1:0]      acc_a
);

   localparam logic [AW-1:0] PC_ONE = {{(AW-1){1'b0}}, 1'b1};
   localparam logic [DW-1:0] LDI_W  = DW'(LDI_CODE);

   seq_state_e    state_q, state_d;
   logic [AW-1:0] pc_q;
   logic [DW-1:0] acc_q;
   logic          is_ldi;

   assign is_ldi = (bus_data_i == LDI_W);

   // Bus writes requested by the sequencer in each cycle type
   always_comb begin
      wr_en   = 1'b0;
      wr_mask = '0;
      wr_addr = pc_q;
      wr_data = '0;
      wr_req  = 1'b0;
      state_d = state_q;
      unique case (state_q)
         ST_FETCH, ST_OPFETCH: begin
            wr_en            = 1'b1;
            wr_mask[FLD_ADDR] = 1'b1;
            wr_mask[FLD_REQ]  = 1'b1;
            wr_req           = 1'b1;
            state_d          = (state_q == ST_FETCH) ? ST_RESP : ST_OPRESP;
         end
         ST_RESP:   state_d = ST_DECODE;
         ST_OPRESP: state_d = ST_LOAD;
         ST_DECODE, ST_LOAD: begin
            wr_en            = 1'b1;
            wr_mask[FLD_REQ] = 1'b1;
            wr_req           = 1'b0;
            if (state_q == ST_LOAD) state_d = ST_FETCH;
            else                    state_d = is_ldi ? ST_OPFETCH : ST_EXEC;
         end
         ST_EXEC:   state_d = ST_FETCH;
         default:   state_d = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         pc_q    <= '0;
         acc_q   <= '0;
      end else begin
         state_q <= state_d;
         unique case (state_q)
            ST_DECODE: if (is_ldi) pc_q <= pc_q + PC_ONE;
            ST_EXEC:   pc_q <= pc_q + PC_ONE;
            ST_LOAD: begin
               acc_q <= bus_data_i;
               pc_q  <= pc_q + PC_ONE;
            end
            default: ;
         endcase
      end
   end

   assign acc_a = acc_q;

endmodule

// File: rtl/cpu_bus_seq.sv
module cpu_bus_seq
   import cbs_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  NOP_CODE = 8'h00,
   parameter logic [7:0]  LDI_CODE = 8'h3E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_wr_en,
   input  logic [DATA_W-1:0] mem_wr_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_req,
   output logic [DATA_W-1:0] acc_a
);

   generate
      if (ADDR_W < 2)            begin : g_bad_aw  $error("cpu_bus_seq: ADDR_W too small"); end
      if (DATA_W < 8)            begin : g_bad_dw  $error("cpu_bus_seq: DATA_W below 8"); end
      if (NOP_CODE == LDI_CODE)  begin : g_bad_op  $error("cpu_bus_seq: opcodes collide"); end
   endgenerate

   logic               cpu_wr_en;
   logic [NUM_FLD-1:0] cpu_wr_mask;
   logic [ADDR_W-1:0]  cpu_wr_addr;
   logic [DATA_W-1:0]  cpu_wr_data;
   logic               cpu_wr_req;

   logic [NUM_WR-1:0]              w_en;
   logic [NUM_WR-1:0][NUM_FLD-1:0] w_mask;
   logic [NUM_WR-1:0][ADDR_W-1:0]  w_addr;
   logic [NUM_WR-1:0][DATA_W-1:0]  w_data;
   logic [NUM_WR-1:0]              w_req;

   logic               u_en;
   logic [NUM_FLD-1:0] u_mask;
   logic [ADDR_W-1:0]  u_addr;
   logic [DATA_W-1:0]  u_data;
   logic               u_req;

   seq_ctrl #(.AW(ADDR_W), .DW(DATA_W), .LDI_CODE(LDI_CODE)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_data_i (bus_data),
      .wr_en      (cpu_wr_en),
      .wr_mask    (cpu_wr_mask),
      .wr_addr    (cpu_wr_addr),
      .wr_data    (cpu_wr_data),
      .wr_req     (cpu_wr_req),
      .acc_a      (acc_a)
   );

   // Slot order sets precedence: sequencer first, memory second
   always_comb begin
      w_en[WR_CPU]   = cpu_wr_en;
      w_mask[WR_CPU] = cpu_wr_mask;
      w_addr[WR_CPU] = cpu_wr_addr;
      w_data[WR_CPU] = cpu_wr_data;
      w_req[WR_CPU]  = cpu_wr_req;

      w_en[WR_MEM]           = mem_wr_en;
      w_mask[WR_MEM]         = '0;
      w_mask[WR_MEM][FLD_DATA] = 1'b1;
      w_addr[WR_MEM]         = '0;
      w_data[WR_MEM]         = mem_wr_data;
      w_req[WR_MEM]          = 1'b0;
   end

   bus_wr_arbiter #(.N(NUM_WR), .AW(ADDR_W), .DW(DATA_W)) arb_i (
      .wr_en    (w_en),
      .wr_mask  (w_mask),
      .wr_addr  (w_addr),
      .wr_data  (w_data),
      .wr_req   (w_req),
      .win_en   (u_en),
      .win_mask (u_mask),
      .win_addr (u_addr),
      .win_data (u_data),
      .win_req  (u_req)
   );

   bus_state_reg #(.AW(ADDR_W), .DW(DATA_W)) bus_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (u_en),
      .upd_mask (u_mask),
      .upd_addr (u_addr),
      .upd_data (u_data),
      .upd_req  (u_req),
      .bus_addr (bus_addr),
      .bus_data (bus_data),
      .bus_req  (bus_req)
   );

endmodule

// File: rtl/cpu_bus_seq_chk.sv
module cpu_bus_seq_chk
   import cbs_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [AW-1:0]      bus_addr,
   input logic [DW-1:0]      bus_data,
   input logic               bus_req,
   input logic [DW-1:0]      acc_a,
   input logic               cpu_wr_en,
   input logic [NUM_FLD-1:0] cpu_wr_mask
);

   AST_WIN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cpu_wr_en) && !$past(cpu_wr_mask[FLD_DATA])) |-> $stable(bus_data)); // R2

   AST_ADDR_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bus_addr) |-> $rose(bus_req)); // R3

   AST_REQ_HOLDS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |=> bus_req); // R4

   AST_DATA_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bus_data) |-> ($past(bus_req) && bus_req)); // R4

   AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_req, 2) && $past(bus_req)) |-> !bus_req); // R5

   AST_ACC_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc_a) |-> $fell(bus_req)); // R8

endmodule

bind cpu_bus_seq cpu_bus_seq_chk #(.AW(ADDR_W), .DW(DATA_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_data    (bus_data),
   .bus_req     (bus_req),
   .acc_a       (acc_a),
   .cpu_wr_en   (cpu_wr_en),
   .cpu_wr_mask (cpu_wr_mask)
);

// File: tb/cpu_bus_seq_tb_top.sv
module cpu_bus_seq_tb_top;

   localparam logic [7:0] OP_NOP = 8'h00;
   localparam logic [7:0] OP_LDI = 8'h3E;
   localparam logic [7:0] OP_ODD = 8'h76;

   logic        clk;
   logic        rst_n;
   logic        mem_wr_en;
   logic [7:0]  mem_wr_data;
   logic [15:0] bus_addr;
   logic [7:0]  bus_data;
   logic        bus_req;
   logic [7:0]  acc_a;

   logic [7:0]  mem_arr [16];

   int          n_checks;
   int          n_errors;
   bit          done;

   logic [15:0] pc;
   logic [15:0] exp_addr;
   logic [7:0]  exp_data;
   logic        exp_req;
   logic [7:0]  exp_a;

   cpu_bus_seq dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mem_wr_en   (mem_wr_en),
      .mem_wr_data (mem_wr_data),
      .bus_addr    (bus_addr),
      .bus_data    (bus_data),
      .bus_req     (bus_req),
      .acc_a       (acc_a)
   );

   // Synchronous memory: offers the addressed byte whenever the strobe is high
   assign mem_wr_en   = bus_req;
   assign mem_wr_data = mem_arr[bus_addr[3:0]];

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string what);
      n_checks++;
      if (act !== expv) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, expv);
      end
   endtask

   task automatic chk_bus(input string what);
      chk({16'h0, bus_addr}, {16'h0, exp_addr}, {what, " addr"});
      chk({24'h0, bus_data}, {24'h0, exp_data}, {what, " data"});
      chk({31'h0, bus_req},  {31'h0, exp_req},  {what, " req"});
      chk({24'h0, acc_a},    {24'h0, exp_a},    {what, " acc"});
   endtask

   task automatic tick(input string what);
      @(posedge clk);
      @(negedge clk);
      chk_bus(what);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      exp_addr = 16'h0; exp_data = 8'h0; exp_req = 1'b0; exp_a = 8'h0; pc = 16'h0;
      #1 chk_bus("R1 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      #1 chk_bus("R1 after reset");
   endtask

   task automatic run_instr();
      logic [7:0] opc;
      opc = mem_arr[pc[3:0]];
      exp_addr = pc; exp_req = 1'b1;
      tick("R3 opcode fetch");
      exp_data = opc;
      tick("R4 opcode response");
      exp_req = 1'b0;
      tick("R5 R2 decode, memory write dropped");
      if (opc == OP_LDI) begin
         pc = pc + 16'd1;
         exp_addr = pc; exp_req = 1'b1;
         tick("R7 operand fetch");
         exp_data = mem_arr[pc[3:0]];
         tick("R8 operand response");
         exp_req = 1'b0; exp_a = exp_data;
         tick("R8 R2 load into A");
      end else begin
         tick(opc == OP_NOP ? "R6 nop execute" : "R9 unknown opcode execute");
      end
      pc = pc + 16'd1;
   endtask

   task automatic load_prog(input logic [7:0] v);
      for (int i = 0; i < 16; i++) mem_arr[i] = OP_NOP;
      mem_arr[1] = OP_LDI; mem_arr[2] = v;
      mem_arr[3] = OP_ODD;
      mem_arr[4] = OP_LDI; mem_arr[5] = ~v;
      mem_arr[7] = OP_LDI; mem_arr[8] = v ^ 8'h33;
      mem_arr[9] = 8'hC3;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] ops [6];
      n_checks = 0; n_errors = 0; done = 1'b0;
      rst_n = 1'b0;
      ops[0] = 8'hFF; ops[1] = 8'h00; ops[2] = 8'hA5;
      ops[3] = 8'h5A; ops[4] = 8'h01; ops[5] = 8'h80;
      for (int i = 0; i < 16; i++) mem_arr[i] = OP_NOP;
      repeat (2) @(posedge clk);

      for (int r = 0; r < 6; r++) begin
         load_prog(ops[r]);
         do_reset();
         for (int k = 0; k < 8; k++) run_instr();
         chk({24'h0, acc_a}, {24'h0, ops[r] ^ 8'h33}, "R8 final accumulator");
      end

      // Reset in the middle of an instruction, then restart from address 0
      load_prog(8'hFF);
      do_reset();
      run_instr();
      exp_addr = pc; exp_req = 1'b1;
      tick("R3 fetch before abort");
      do_reset();
      for (int k = 0; k < 3; k++) run_instr();
      chk({24'h0, acc_a}, 24'h0 + 32'hFF, "R8 accumulator after restart");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule